// File: doc/BRIEF.md
# Word Message Mailbox

This block passes messages made of 32-bit words between a host on a simple register bus and a peer agent with valid/ready streams. The host fills a transmit buffer through an auto-incrementing data port and starts a transfer by writing a word count. The block then streams those words to the peer. When the peer hands over a message, the block stores it in a separate receive buffer. It raises an arrival flag and reports the word count, and the host drains the message through a second auto-incrementing port.

Both events appear in one status register as write-one-to-clear flags, together with a sticky flag for rejected lengths. An interrupt output combines the flags with per-flag enables. While an arrived message is still unacknowledged, the block refuses further incoming words, so the buffer cannot be overwritten.

The register word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | status | write one to clear |
| 1 | interrupt enable | read/write |
| 2 | transmit index | write |
| 3 | transmit data | write |
| 4 | transmit length | write |
| 5 | receive index | write |
| 6 | receive data | read |
| 7 | receive length | read |
| 8 | version | read |

Top module: `msg_mailbox`

## Requirements
- R1: After reset the status register (address 0) and the interrupt-enable register (address 1) read 0, `irq` is low, `pk_tx_valid` is low and `pk_rx_ready` is high.
- R2: Writing address 2 sets the transmit pointer. Each write to address 3 stores the word at the pointer and then advances the pointer. After entry DEPTH-1 the pointer returns to entry 0.
- R3: Writing address 4 with a count N, where 1 <= N <= DEPTH, while no transfer is running starts a transfer. `pk_tx_valid` is high from the next cycle. Entries 0 to N-1 are offered in order, each held until it is accepted, and `pk_tx_last` marks entry N-1.
- R4: In the cycle after the final word is accepted, `pk_tx_valid` is low and status bit 1 (transmit done) is set.
- R5: A write of 0 or of more than DEPTH to address 4 starts nothing and sets the sticky status bit 2 (length error).
- R6: Writing status with a 1 in a bit position clears that flag; a 0 leaves it unchanged. An event arriving in the same cycle as a clear wins.
- R7: Incoming words are stored from receive entry 0 onward. In the cycle after the word marked last is accepted, status bit 0 (message arrived) is set and address 7 returns the word count.
- R8: `pk_rx_ready` is low whenever status bit 0 is set.
- R9: Writing address 5 sets the receive pointer. Each read of address 6 returns the entry at the pointer and then advances the pointer, wrapping after DEPTH-1. Entries at or beyond the receive length read as 0.
- R10: `irq` is high exactly when (status bit 0 and enable bit 0) or (status bit 1 and enable bit 1) holds.
- R11: Address 8 always returns the VERSION parameter.
- R12: A write to address 4 while a transfer is running is ignored and does not set the error bit.
- R13: Incoming words beyond DEPTH in one message are dropped, and the receive length then reports DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host register write strobe |
| hb_rd | input | 1 | Host register read strobe (used for read side effects) |
| hb_addr | input | 4 | Host register word address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid in the same cycle as the address |
| pk_tx_valid | output | 1 | Outgoing word valid |
| pk_tx_ready | input | 1 | Peer accepts the outgoing word |
| pk_tx_data | output | 32 | Outgoing word |
| pk_tx_last | output | 1 | Outgoing word is the last of the message |
| pk_rx_valid | input | 1 | Incoming word valid |
| pk_rx_ready | output | 1 | Block accepts the incoming word |
| pk_rx_data | input | 32 | Incoming word |
| pk_rx_last | input | 1 | Incoming word ends the message |
| irq | output | 1 | Interrupt request |

## Verification
Host writes take effect at the clock edge that samples them and are visible from the following cycle. Host read data is combinational, so it is valid in the same cycle as the address. A length write raises `pk_tx_valid` one cycle later. The done flag, the arrival flag and the drop of `pk_rx_ready` all appear one cycle after the final handshake, and `irq` follows the flags with no further delay. The bench changes inputs and samples outputs only at falling edges. Each result is therefore read in the half-cycle after the rising edge that should have produced it.

// File: rtl/msg_mailbox.sv
module msg_mailbox #(
  parameter int          DEPTH   = 64,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_wr,
  input  logic        hb_rd,
  input  logic [3:0]  hb_addr,
  input  logic [31:0] hb_wdata,
  output logic [31:0] hb_rdata,
  output logic        pk_tx_valid,
  input  logic        pk_tx_ready,
  output logic [31:0] pk_tx_data,
  output logic        pk_tx_last,
  input  logic        pk_rx_valid,
  output logic        pk_rx_ready,
  input  logic [31:0] pk_rx_data,
  input  logic        pk_rx_last,
  output logic        irq
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int LENW = $clog2(DEPTH + 1);
  localparam logic [LENW-1:0] FULL = LENW'(DEPTH);

  localparam logic [3:0] A_STAT = 4'd0, A_IEN = 4'd1, A_TIDX = 4'd2, A_TDAT = 4'd3,
                         A_TLEN = 4'd4, A_RIDX = 4'd5, A_RDAT = 4'd6, A_RLEN = 4'd7,
                         A_VER  = 4'd8;

  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];

  logic [IDXW-1:0] tx_wptr, tx_pos, rx_rptr;
  logic [LENW-1:0] tx_len, rx_len, rx_cnt;
  logic            tx_busy, rx_evt, tx_evt, len_err;
  logic [1:0]      ien;

  wire wr_stat = hb_wr && hb_addr == A_STAT;
  wire wr_tdat = hb_wr && hb_addr == A_TDAT;
  wire wr_tlen = hb_wr && hb_addr == A_TLEN;
  wire rd_rdat = hb_rd && hb_addr == A_RDAT;
  wire len_ok  = hb_wdata != 32'd0 && hb_wdata <= 32'(DEPTH);
  wire tx_go   = pk_tx_valid && pk_tx_ready;
  wire tx_end  = tx_go && pk_tx_last;
  wire rx_go   = pk_rx_valid && pk_rx_ready;
  wire rx_room = rx_cnt < FULL;

  assign pk_tx_valid = tx_busy;
  assign pk_tx_data  = tx_mem[tx_pos];
  assign pk_tx_last  = tx_busy && LENW'(tx_pos) == tx_len - LENW'(1);
  assign pk_rx_ready = !rx_evt;
  assign irq         = (rx_evt && ien[0]) || (tx_evt && ien[1]);

  always_ff @(posedge clk) begin
    if (wr_tdat) tx_mem[tx_wptr] <= hb_wdata;
    if (rx_go && rx_room) rx_mem[rx_cnt[IDXW-1:0]] <= pk_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wptr <= '0;
      tx_pos  <= '0;
      tx_len  <= '0;
      tx_busy <= 1'b0;
      tx_evt  <= 1'b0;
      len_err <= 1'b0;
      ien     <= '0;
    end else begin
      if (hb_wr && hb_addr == A_IEN) ien <= hb_wdata[1:0];
      if (hb_wr && hb_addr == A_TIDX) tx_wptr <= hb_wdata[IDXW-1:0];
      else if (wr_tdat) tx_wptr <= tx_wptr + IDXW'(1);
      if (wr_stat && hb_wdata[1]) tx_evt  <= 1'b0;
      if (wr_stat && hb_wdata[2]) len_err <= 1'b0;
      if (wr_tlen && !tx_busy) begin
        if (len_ok) begin
          tx_busy <= 1'b1;
          tx_len  <= hb_wdata[LENW-1:0];
          tx_pos  <= '0;
        end else begin
          len_err <= 1'b1;
        end
      end else if (tx_go) begin
        tx_pos <= tx_pos + IDXW'(1);
        if (pk_tx_last) begin
          tx_busy <= 1'b0;
          tx_evt  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt  <= '0;
      rx_len  <= '0;
      rx_evt  <= 1'b0;
      rx_rptr <= '0;
    end else begin
      if (wr_stat && hb_wdata[0]) rx_evt <= 1'b0;
      if (rx_go) begin
        if (pk_rx_last) begin
          rx_evt <= 1'b1;
          rx_len <= rx_room ? rx_cnt + LENW'(1) : FULL;
          rx_cnt <= '0;
        end else if (rx_room) begin
          rx_cnt <= rx_cnt + LENW'(1);
        end
      end
      if (hb_wr && hb_addr == A_RIDX) rx_rptr <= hb_wdata[IDXW-1:0];
      else if (rd_rdat) rx_rptr <= rx_rptr + IDXW'(1);
    end
  end

  always_comb begin
    hb_rdata = '0;
    case (hb_addr)
      A_STAT: hb_rdata = {29'd0, len_err, tx_evt, rx_evt};
      A_IEN:  hb_rdata = {30'd0, ien};
      A_RDAT: hb_rdata = (LENW'(rx_rptr) < rx_len) ? rx_mem[rx_rptr] : 32'd0;
      A_RLEN: hb_rdata = 32'(rx_len);
      A_VER:  hb_rdata = VERSION;
      default: hb_rdata = '0;
    endcase
  end

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pk_tx_valid && !pk_tx_ready |=> pk_tx_valid);
  p_tx_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> tx_evt && !pk_tx_valid);
  p_bad_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tlen && !tx_busy && !len_ok |=> len_err && !pk_tx_valid);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err && !(wr_stat && hb_wdata[2]) |=> len_err);
  p_rx_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> !pk_rx_ready);
  p_busy_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tlen && tx_busy && !tx_end |=> pk_tx_valid && $stable(tx_len));
  p_rx_cap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len <= FULL);
endmodule

// File: tb/msg_mailbox_tb.sv
module msg_mailbox_tb;
  localparam int D = 64;
  localparam logic [31:0] VER = 32'h0001_0300;
  localparam logic [40:0] VEC [4] = '{
    {1'b0, 8'd1,  32'hA000_0000},
    {1'b1, 8'd5,  32'h1234_5600},
    {1'b0, 8'd64, 32'h0BAD_F000},
    {1'b1, 8'd3,  32'hFFFF_FFFE}
  };

  logic clk = 0, rst_n = 0;
  logic hb_wr = 0, hb_rd = 0;
  logic [3:0] hb_addr = 0;
  logic [31:0] hb_wdata = 0, hb_rdata;
  logic pk_tx_valid, pk_tx_ready = 0, pk_tx_last;
  logic [31:0] pk_tx_data;
  logic pk_rx_valid = 0, pk_rx_ready, pk_rx_last = 0;
  logic [31:0] pk_rx_data = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  msg_mailbox u_dut (.clk, .rst_n, .hb_wr, .hb_rd, .hb_addr, .hb_wdata, .hb_rdata,
    .pk_tx_valid, .pk_tx_ready, .pk_tx_data, .pk_tx_last,
    .pk_rx_valid, .pk_rx_ready, .pk_rx_data, .pk_rx_last, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); hb_wr = 1; hb_addr = a; hb_wdata = d;
    @(negedge clk); hb_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); hb_rd = 1; hb_addr = a; #1 d = hb_rdata;
    @(negedge clk); hb_rd = 0;
  endtask

  task automatic drain(int n, logic [31:0] seed, logic stall, output int got, output int bad);
    got = 0; bad = 0;
    for (int c = 0; c < 6 * D && got < n; c++) begin
      pk_tx_ready = stall ? c[0] : 1'b1;
      #1;
      if (pk_tx_valid && pk_tx_ready) begin
        if (pk_tx_data !== seed + 32'(got) || pk_tx_last !== (got == n - 1)) bad++;
        got++;
      end
      @(negedge clk);
    end
    pk_tx_ready = 0;
  endtask

  task automatic peer_send(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      pk_rx_valid = 1; pk_rx_data = seed + 32'(i); pk_rx_last = (i == n - 1);
      #1;
      while (!pk_rx_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    pk_rx_valid = 0; pk_rx_last = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int got, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd0, v); check("R1 status", v, 0);
    rd(4'd1, v); check("R1 irq enable", v, 0);
    check("R1 outputs", {irq, pk_tx_valid, pk_rx_ready}, 3'b001);
    rd(4'd8, v); check("R11 version", v, VER);

    wr(4'd1, 32'd2);
    foreach (VEC[k]) begin
      wr(4'd2, 0);
      for (int i = 0; i < int'(VEC[k][39:32]); i++) wr(4'd3, VEC[k][31:0] + 32'(i));
      wr(4'd4, 32'(VEC[k][39:32]));
      check("R3 valid after length", pk_tx_valid, 1);
      drain(int'(VEC[k][39:32]), VEC[k][31:0], VEC[k][40], got, bad);
      check("R3 words delivered", got, 32'(VEC[k][39:32]));
      check("R3 word contents", bad, 0);
      rd(4'd0, v);
      check("R4 done flag", v, 32'd2);
      check("R4 valid low", pk_tx_valid, 0);
      check("R10 irq on done", irq, 1);
      wr(4'd0, 32'd2);
      rd(4'd0, v); check("R6 done cleared", v, 0);
    end

    wr(4'd4, 0);
    check("R5 zero length no transfer", pk_tx_valid, 0);
    wr(4'd0, 0);
    rd(4'd0, v); check("R5 R6 error sticky after zero write", v, 32'd4);
    wr(4'd0, 32'd4);
    wr(4'd4, 32'd65);
    rd(4'd0, v); check("R5 oversize error", v, 32'd4);
    check("R5 oversize no transfer", pk_tx_valid, 0);
    wr(4'd0, 32'd4);
    rd(4'd0, v); check("R6 error cleared", v, 0);

    wr(4'd2, 32'd63); wr(4'd3, 32'hAAAA_0001); wr(4'd3, 32'hBBBB_0002);
    wr(4'd4, 32'd1);
    #1 check("R2 pointer wrap to entry 0", pk_tx_data, 32'hBBBB_0002);
    drain(1, 32'hBBBB_0002, 0, got, bad);
    wr(4'd0, 32'd2);

    wr(4'd2, 0); wr(4'd3, 32'h100); wr(4'd3, 32'h101); wr(4'd3, 32'h102);
    wr(4'd4, 32'd3);
    wr(4'd4, 32'd5);
    drain(8, 32'h100, 0, got, bad);
    check("R12 busy length ignored", got, 3);
    rd(4'd0, v); check("R12 no error while busy", v, 32'd2);
    wr(4'd0, 32'd2);

    wr(4'd1, 32'd1);
    peer_send(4, 32'h5500_0000);
    rd(4'd0, v); check("R7 arrival flag", v, 32'd1);
    rd(4'd7, v); check("R7 receive length", v, 4);
    check("R8 ready low", pk_rx_ready, 0);
    check("R10 irq on arrival", irq, 1);
    wr(4'd5, 0);
    bad = 0;
    for (int i = 0; i < 4; i++) begin rd(4'd6, v); if (v !== 32'h5500_0000 + 32'(i)) bad++; end
    check("R9 sequential read", bad, 0);
    rd(4'd6, v); check("R9 beyond length reads 0", v, 0);
    wr(4'd1, 32'd0);
    check("R10 irq masked", irq, 0);
    wr(4'd0, 32'd1);
    check("R8 ready restored", pk_rx_ready, 1);

    peer_send(66, 32'h7700_0000);
    rd(4'd7, v); check("R13 length saturates", v, 64);
    wr(4'd5, 32'd63);
    rd(4'd6, v); check("R13 last kept word", v, 32'h7700_003F);
    rd(4'd6, v); check("R9 read pointer wrap", v, 32'h7700_0000);
    wr(4'd0, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule